// File: doc/BRIEF.md
# Power-Fail Write-Protect Supervisor

This block guards a battery-backed static memory against corruption while its supply is unsettled. It watches three supply comparator flags, resynchronizes them to a free-running clock, and decides whether the host's chip-enable, write-enable and output-enable strobes may reach the memory array. Whenever the supply is out of tolerance, the block forces the array strobes inactive and turns the data drivers off. It then keeps that protection for a fixed recovery interval after the supply comes back.

A lower comparator flag moves the array onto its backup battery. A one-time seal keeps the battery disconnected from reset until the supply first becomes valid. A state code on an output lets the surrounding logic and the testbench follow the supervisor through power ramps.

Top module: `pf_guard`

## Requirements
- R1: While reset is asserted and just after it, state_o is 0 (sealed), bat_en_o and bat_sel_o are 0, arr_ce_no and arr_we_no are 1, and dq_oe_o is 0.
- R2: In the sealed state every host strobe is ignored and the battery is never selected, even with sup_low_i high. The block leaves the sealed state only when sup_valid_i is 1 and sup_trip_i is 0. It then goes to the recovering state (code 4).
- R3: bat_en_o becomes 1 on the exit from the sealed state and stays 1 until the next reset.
- R4: In the normal state (code 1), arr_ce_no equals ce_ni. arr_we_no is low only when ce_ni and we_ni are both low. dq_oe_o is high only when ce_ni and oe_ni are low and we_ni is high.
- R5: In the normal state, sup_trip_i high or sup_valid_i low moves the block to the protected state (code 2). This forces arr_ce_no and arr_we_no high and dq_oe_o low, which cuts short any write in progress.
- R6: Protection ends only when sup_valid_i is 1 and sup_trip_i is 0 together. sup_trip_i low alone, with sup_valid_i still low, keeps the protected state.
- R7: sup_low_i high in any state other than sealed leads to the battery state (code 3) with bat_sel_o = 1. This path has priority over every other transition. When sup_low_i falls, the block returns to the protected state and bat_sel_o returns to 0.
- R8: The recovering state keeps all protection for exactly REC_CYC clock cycles. It then enters the normal state.
- R9: sup_trip_i high or sup_valid_i low during recovery returns the block to the protected state. The next recovery counts a full REC_CYC cycles from zero.
- R10: A change on the supply flags takes effect on the outputs at the third rising clock edge after it: two synchronizer stages and the state register. When a fail condition has held for FAIL_CYC cycles, arr_ce_no and arr_we_no must already be high.
- R11: state_o reports the current state with the codes sealed=0, normal=1, protected=2, battery=3, recovering=4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sup_valid_i | input | 1 | Supply above the upper valid level (asynchronous) |
| sup_trip_i | input | 1 | Supply at or below the write-protect trip level (asynchronous) |
| sup_low_i | input | 1 | Supply below the battery switchover level (asynchronous) |
| ce_ni | input | 1 | Host chip enable, active low |
| we_ni | input | 1 | Host write enable, active low |
| oe_ni | input | 1 | Host output enable, active low |
| arr_ce_no | output | 1 | Gated chip enable to the array, active low |
| arr_we_no | output | 1 | Gated write enable to the array, active low |
| dq_oe_o | output | 1 | Data output driver enable, 1 = drive |
| bat_sel_o | output | 1 | 1 = array powered from the battery |
| bat_en_o | output | 1 | Seal broken; battery backup enabled |
| state_o | output | 3 | Current supervisor state code |

## Verification
The bench builds the block with REC_CYC = 8 and FAIL_CYC = 3. With these values a full recovery window, and a glitch landing inside one, fit in a few dozen cycles instead of millions. The bench can therefore take the supervisor through several complete power-down, battery and power-up sequences. FAIL_CYC = 3 is the smallest deadline that the synchronizer-plus-state latency can meet, so the deadline property is exercised at its tightest.

// File: rtl/pfg_pkg.sv
package pfg_pkg;
  typedef enum logic [2:0] {
    ST_SEALED = 3'd0,
    ST_NORMAL = 3'd1,
    ST_PROT   = 3'd2,
    ST_BATT   = 3'd3,
    ST_RECOV  = 3'd4
  } pf_state_e;
endpackage

// File: rtl/pfg_sync.sv
module pfg_sync #(
  parameter int             W   = 3,
  parameter logic [W-1:0]   RST = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= RST;
      s2_q <= RST;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/pfg_fsm.sv
module pfg_fsm
  import pfg_pkg::*;
#(
  parameter int REC_CYC = 16
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      valid_i,
  input  logic      trip_i,
  input  logic      low_i,
  output pf_state_e state_o,
  output logic      bat_en_o,
  output logic      bat_sel_o
);
  localparam int CW = (REC_CYC < 2) ? 1 : $clog2(REC_CYC);

  pf_state_e       state_q, state_d;
  logic [CW-1:0]   cnt_q;
  logic            bat_en_q;
  logic            ok, fail, done;

  assign ok   = valid_i & ~trip_i;
  assign fail = ~ok;
  assign done = (cnt_q == CW'(REC_CYC - 1));

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_SEALED: if (ok) state_d = ST_RECOV;
      ST_NORMAL: if (low_i) state_d = ST_BATT;
                 else if (fail) state_d = ST_PROT;
      ST_PROT:   if (low_i) state_d = ST_BATT;
                 else if (ok) state_d = ST_RECOV;
      ST_BATT:   if (!low_i) state_d = ST_PROT;
      ST_RECOV:  if (low_i) state_d = ST_BATT;
                 else if (fail) state_d = ST_PROT;
                 else if (done) state_d = ST_NORMAL;
      default:   state_d = ST_SEALED;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_SEALED;
      cnt_q    <= '0;
      bat_en_q <= 1'b0;
    end else begin
      state_q <= state_d;
      // counter only runs while recovery continues; any exit clears it
      if (state_q == ST_RECOV && state_d == ST_RECOV) cnt_q <= cnt_q + 1'b1;
      else                                            cnt_q <= '0;
      if (state_q == ST_SEALED && ok) bat_en_q <= 1'b1;
    end
  end

  assign state_o   = state_q;
  assign bat_en_o  = bat_en_q;
  assign bat_sel_o = (state_q == ST_BATT);

  p_seal_sticky_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bat_en_q |=> bat_en_q);

  p_no_batt_sealed_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bat_en_q |-> state_q != ST_BATT);

  p_rec_full_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_NORMAL && $past(state_q) != ST_NORMAL)
      |-> ($past(state_q) == ST_RECOV && $past(cnt_q) == CW'(REC_CYC - 1)));

  p_rec_restart_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RECOV && $past(state_q) != ST_RECOV) |-> cnt_q == '0);

  p_low_priority_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (low_i && state_q != ST_SEALED) |=> state_q == ST_BATT);
endmodule

// File: rtl/pfg_gate.sv
module pfg_gate
  import pfg_pkg::*;
(
  input  pf_state_e state_i,
  input  logic      ce_ni,
  input  logic      we_ni,
  input  logic      oe_ni,
  output logic      arr_ce_no,
  output logic      arr_we_no,
  output logic      dq_oe_o
);
  logic allow;

  assign allow     = (state_i == ST_NORMAL);
  assign arr_ce_no = ~(allow & ~ce_ni);
  assign arr_we_no = ~(allow & ~ce_ni & ~we_ni);
  // a low write enable keeps the drivers off to avoid bus contention
  assign dq_oe_o   = allow & ~ce_ni & ~oe_ni & we_ni;
endmodule

// File: rtl/pf_guard.sv
module pf_guard
  import pfg_pkg::*;
#(
  parameter int REC_CYC  = 12_500_000,
  parameter int FAIL_CYC = 150
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sup_valid_i,
  input  logic       sup_trip_i,
  input  logic       sup_low_i,
  input  logic       ce_ni,
  input  logic       we_ni,
  input  logic       oe_ni,
  output logic       arr_ce_no,
  output logic       arr_we_no,
  output logic       dq_oe_o,
  output logic       bat_sel_o,
  output logic       bat_en_o,
  output logic [2:0] state_o
);
  localparam int          NFLAG  = 3;
  localparam logic [NFLAG-1:0] FLAG_RST = 3'b011; // invalid, tripped, low
  localparam int          AW     = $clog2(FAIL_CYC + 1);

  logic [NFLAG-1:0] flags_s;
  pf_state_e        state;

  pfg_sync #(.W(NFLAG), .RST(FLAG_RST)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({sup_valid_i, sup_trip_i, sup_low_i}),
    .q_o   (flags_s)
  );

  pfg_fsm #(.REC_CYC(REC_CYC)) u_fsm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .valid_i  (flags_s[2]),
    .trip_i   (flags_s[1]),
    .low_i    (flags_s[0]),
    .state_o  (state),
    .bat_en_o (bat_en_o),
    .bat_sel_o(bat_sel_o)
  );

  pfg_gate u_gate (
    .state_i  (state),
    .ce_ni    (ce_ni),
    .we_ni    (we_ni),
    .oe_ni    (oe_ni),
    .arr_ce_no(arr_ce_no),
    .arr_we_no(arr_we_no),
    .dq_oe_o  (dq_oe_o)
  );

  assign state_o = state;

  // deadline checker: consecutive cycles of raw fail
  logic [AW-1:0] fail_age;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                           fail_age <= '0;
    else if (sup_valid_i && !sup_trip_i)   fail_age <= '0;
    else if (fail_age != AW'(FAIL_CYC))    fail_age <= fail_age + 1'b1;
  end

  p_fail_deadline_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_age == AW'(FAIL_CYC) |-> (arr_ce_no && arr_we_no && !dq_oe_o));

  p_protect_blocks_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state != ST_NORMAL |-> (arr_ce_no && arr_we_no && !dq_oe_o));

  p_bat_only_enabled_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bat_sel_o |-> bat_en_o);
endmodule

// File: tb/sim_pf_guard.sv
module sim_pf_guard;
  localparam int REC   = 8;
  localparam int FAILC = 3;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic sup_valid = 1'b0, sup_trip = 1'b1, sup_low = 1'b1;
  logic ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic arr_ce_n, arr_we_n, dq_oe, bat_sel, bat_en;
  logic [2:0] state;

  int errors = 0;
  int checks = 0;

  always #5 clk = ~clk;

  pf_guard #(.REC_CYC(REC), .FAIL_CYC(FAILC)) u0 (
    .clk_i(clk), .rst_ni(rst_ni),
    .sup_valid_i(sup_valid), .sup_trip_i(sup_trip), .sup_low_i(sup_low),
    .ce_ni(ce_n), .we_ni(we_n), .oe_ni(oe_n),
    .arr_ce_no(arr_ce_n), .arr_we_no(arr_we_n), .dq_oe_o(dq_oe),
    .bat_sel_o(bat_sel), .bat_en_o(bat_en), .state_o(state)
  );

  typedef struct {
    logic [2:0] st;
    logic ce, we, oe, bs, be;
    string tag;
  } exp_t;

  exp_t q[$];

  // reference model
  int rs = 0;
  int rc = 0;
  bit rbe = 0;
  bit hv[3] = '{0, 0, 0};
  bit ht[3] = '{1, 1, 1};
  bit hl[3] = '{1, 1, 1};

  task automatic step(input bit v, input bit t, input bit l,
                      input bit c, input bit w, input bit o, input string tag);
    exp_t e;
    bit ok, allow;
    @(negedge clk);
    sup_valid = v; sup_trip = t; sup_low = l;
    ce_n = c; we_n = w; oe_n = o;
    hv[2] = hv[1]; hv[1] = hv[0]; hv[0] = v;
    ht[2] = ht[1]; ht[1] = ht[0]; ht[0] = t;
    hl[2] = hl[1]; hl[1] = hl[0]; hl[0] = l;
    ok = hv[2] && !ht[2];
    case (rs)
      0: if (ok) begin rs = 4; rbe = 1; rc = 0; end
      1: if (hl[2]) rs = 3; else if (!ok) rs = 2;
      2: if (hl[2]) rs = 3; else if (ok) begin rs = 4; rc = 0; end
      3: if (!hl[2]) rs = 2;
      default: if (hl[2]) rs = 3;
               else if (!ok) rs = 2;
               else if (rc == REC - 1) rs = 1;
               else rc++;
    endcase
    allow = (rs == 1);
    e.st  = 3'(rs);
    e.ce  = !(allow && !c);
    e.we  = !(allow && !c && !w);
    e.oe  = allow && !c && !o && w;
    e.bs  = (rs == 3);
    e.be  = rbe;
    e.tag = tag;
    q.push_back(e);
  endtask

  task automatic hold(input int n, input string tag);
    for (int i = 0; i < n; i++)
      step(sup_valid, sup_trip, sup_low, ce_n, we_n, oe_n, tag);
  endtask

  // monitor: pop and compare just after each rising edge
  always @(posedge clk) begin
    exp_t e;
    #1;
    if (rst_ni && q.size() > 0) begin
      e = q.pop_front();
      checks++;
      if (state !== e.st || arr_ce_n !== e.ce || arr_we_n !== e.we ||
          dq_oe !== e.oe || bat_sel !== e.bs || bat_en !== e.be) begin
        errors++;
        $display("FAIL %s R11: st/ce/we/oe/bs/be act=%0d/%b/%b/%b/%b/%b exp=%0d/%b/%b/%b/%b/%b",
                 e.tag, state, arr_ce_n, arr_we_n, dq_oe, bat_sel, bat_en,
                 e.st, e.ce, e.we, e.oe, e.bs, e.be);
      end
    end
  end

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog: act=running exp=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // R1: reset state
    #22;
    checks++;
    if (state !== 3'd0 || bat_en !== 1'b0 || bat_sel !== 1'b0 ||
        arr_ce_n !== 1'b1 || arr_we_n !== 1'b1 || dq_oe !== 1'b0) begin
      errors++;
      $display("FAIL R1: st/ce/we/oe/bs/be act=%0d/%b/%b/%b/%b/%b exp=0/1/1/0/0/0",
               state, arr_ce_n, arr_we_n, dq_oe, bat_sel, bat_en);
    end
    @(negedge clk);
    rst_ni = 1'b1;

    // R2: sealed, host write attempts and low supply ignored
    step(0, 1, 1, 0, 0, 0, "R2");
    hold(6, "R2");
    step(0, 1, 0, 0, 1, 0, "R2");
    hold(3, "R2");

    // first power-up: seal breaks (R3), recovery (R8), then normal (R4)
    step(1, 0, 0, 0, 0, 1, "R3");
    hold(3, "R3");
    hold(REC + 3, "R8");

    // R4: host patterns in normal
    step(1, 0, 0, 0, 1, 0, "R4");
    hold(2, "R4");
    step(1, 0, 0, 1, 1, 0, "R4");
    step(1, 0, 0, 0, 0, 0, "R4");
    step(1, 0, 0, 0, 1, 1, "R4");
    step(1, 0, 0, 1, 0, 0, "R4");

    // R5/R10: trip during a write terminates it
    step(1, 0, 0, 0, 0, 1, "R5");
    step(1, 1, 0, 0, 0, 1, "R10");
    hold(5, "R5");

    // R6: trip clears but valid still low -> protection held
    step(0, 0, 0, 0, 0, 1, "R6");
    hold(6, "R6");

    // R9: glitch in recovery restarts the count
    step(1, 0, 0, 0, 0, 1, "R9");
    hold(5, "R9");
    step(1, 1, 0, 0, 0, 1, "R9");
    step(1, 0, 0, 0, 0, 1, "R9");
    hold(REC + 6, "R8");

    // R7: power-down to battery and back up
    step(0, 1, 0, 0, 1, 0, "R10");
    hold(4, "R5");
    step(0, 1, 1, 0, 0, 0, "R7");
    hold(6, "R7");
    step(0, 1, 0, 0, 0, 0, "R7");
    hold(4, "R7");
    step(1, 0, 0, 0, 1, 0, "R8");
    hold(REC + 5, "R8");

    // R7: low flag straight from normal takes priority over trip
    step(0, 1, 1, 0, 0, 0, "R7");
    hold(5, "R7");
    step(1, 0, 0, 1, 1, 1, "R3");
    hold(REC + 6, "R11");

    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule